// File: doc/BRIEF.md
# Interlaced Field Parity Detector

This block decides whether an interlaced video field is odd or even. Its inputs, both on the system clock, are the sliced composite sync level and a one-cycle strobe that marks the start of each vertical pulse. It follows the horizontal sync leading edges and learns the line period from them. It then measures where each vertical start falls within the current line. A vertical start that lands near a line boundary gives one parity. A vertical start that lands about half a line in gives the other.

The field output changes only in the cycle after a vertical start strobe, and it holds its value between strobes. Short pulses in the vertical interval, such as equalizing pulses, arrive at half-line spacing. These pulses are rejected, so they do not disturb the line reference. The block learns the line period by averaging consecutive full-line spacings, so it works at different scan rates without reconfiguration. Progressive input places every vertical start at the same phase, so the output holds one value and does not alternate.

Top module: `field_parity_top`

## Requirements
- R1: While `rst_ni` is low and right after reset, `field_odd_o` is 0 and no line period is learned. The first vertical start after reset therefore counts as undecidable (see R7) and drives the output to 1.
- R2: `field_odd_o` changes only on the clock edge that samples `vstart_i` high. Its new value is visible from the following cycle, and it is stable in every other cycle.
- R3: A sync leading edge is a cycle where `csync_i` is 0 and was 1 in the previous cycle. Spacing is the number of cycles between two accepted edges. The line period P becomes valid after 2^AVG_LOG2 consecutive spacings (4 by default), each within ±(first/8) of the first spacing of the run. P is their average, truncated. A spacing outside that window starts a new run. Every vertical start before P is valid counts as undecidable.
- R4: Once P is valid, a leading edge that comes fewer than P − P/8 cycles after the last accepted edge is ignored and does not restart the reference. Any later edge is accepted.
- R5: The phase is the number of cycles from the last accepted edge to the cycle of the vertical start. It is 0 when an edge is accepted in that same cycle. With tol = P/8, a phase ≤ tol or ≥ P − tol sets `field_odd_o` to 1 (odd field).
- R6: A phase with |phase − P/2| ≤ tol (P/2 truncated) sets `field_odd_o` to 0 (even field).
- R7: Any other phase is undecidable, and the output inverts its previous value.
- R8: Vertical starts that alternate between half-line and whole-line phase make the output alternate. Repeated whole-line phases (progressive scan) hold the output at 1.
- R9: After a reset, the block learns a different line period from the sync stream alone and applies the windows of R5 to R7 scaled to that period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csync_i | input | 1 | Sliced composite sync, low during sync |
| vstart_i | input | 1 | One-cycle strobe at the start of a vertical pulse |
| field_odd_o | output | 1 | Field parity: 1 odd, 0 even |

## Verification
The assertions check on every cycle the following: the output stays stable between vertical start strobes, the output is cleared in reset, the learned-period lock is sticky, every verdict is applied correctly to the output, and every verdict is undecidable before lock. Only the bench's scenarios can show that the phase windows and their boundaries are placed correctly. The bench also shows that half-line equalizing pulses leave the reference untouched, that the averaged period matches the stream's real line length, and that a second scan rate is learned after reset. It does this with a sweep of the vertical start over every phase of a line at two line periods.

// File: rtl/fpd_pkg.sv
`timescale 1ns/1ps
package fpd_pkg;
  typedef enum logic [1:0] {
    VERD_EVEN   = 2'd0,
    VERD_ODD    = 2'd1,
    VERD_UNSURE = 2'd2
  } verdict_e;
endpackage

// File: rtl/fpd_edge_gate.sv
`timescale 1ns/1ps
// Sync leading-edge detection, edge acceptance and line-phase counter.
module fpd_edge_gate #(
  parameter int CNT_W     = 12,
  parameter int TOL_SHIFT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             csync_i,
  input  logic             locked_i,
  input  logic [CNT_W-1:0] period_i,
  output logic             accept_o,
  output logic             ref_valid_o,
  output logic             spacing_vld_o,
  output logic [CNT_W-1:0] gap_o
);
  localparam logic [CNT_W-1:0] GAP_MAX = '1;
  localparam logic [CNT_W-1:0] GAP_ONE = CNT_W'(1);

  logic             csync_q;
  logic             ref_valid_q;
  logic [CNT_W-1:0] gap_q;
  logic             lead;
  logic [CNT_W-1:0] min_gap;

  assign lead    = csync_q & ~csync_i;
  assign min_gap = period_i - (period_i >> TOL_SHIFT);
  // before lock every edge restarts the reference; after lock only long gaps
  assign accept_o = lead & (~locked_i | ~ref_valid_q | (gap_q >= min_gap));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      csync_q     <= 1'b1;
      ref_valid_q <= 1'b0;
      gap_q       <= GAP_MAX;
    end else begin
      csync_q <= csync_i;
      if (accept_o) begin
        ref_valid_q <= 1'b1;
        gap_q       <= GAP_ONE;
      end else if (gap_q != GAP_MAX) begin
        gap_q <= gap_q + GAP_ONE;
      end
    end
  end

  assign ref_valid_o   = ref_valid_q;
  assign spacing_vld_o = accept_o & ref_valid_q;
  assign gap_o         = gap_q;
endmodule

// File: rtl/fpd_period_learn.sv
`timescale 1ns/1ps
// Learns the line period as the mean of consecutive matching spacings.
module fpd_period_learn #(
  parameter int CNT_W     = 12,
  parameter int AVG_LOG2  = 2,
  parameter int TOL_SHIFT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             spacing_vld_i,
  input  logic [CNT_W-1:0] spacing_i,
  output logic             locked_o,
  output logic [CNT_W-1:0] period_o
);
  localparam int              N_AVG = 1 << AVG_LOG2;
  localparam int              SUM_W = CNT_W + AVG_LOG2;
  localparam int              RUN_W = AVG_LOG2 + 1;
  localparam logic [RUN_W-1:0] RUN_FULL = RUN_W'(N_AVG);
  localparam logic [RUN_W-1:0] RUN_ONE  = RUN_W'(1);

  logic [CNT_W-1:0] run_ref_q;
  logic [SUM_W-1:0] run_sum_q;
  logic [RUN_W-1:0] run_cnt_q;
  logic             locked_q;
  logic [CNT_W-1:0] period_q;

  logic [CNT_W-1:0] diff;
  logic             match;
  logic             start_new;
  logic [SUM_W-1:0] nxt_sum;
  logic [RUN_W-1:0] nxt_cnt;
  logic [SUM_W-1:0] spacing_ext;

  assign spacing_ext = {{AVG_LOG2{1'b0}}, spacing_i};

  always_comb begin
    diff      = (spacing_i > run_ref_q) ? (spacing_i - run_ref_q) : (run_ref_q - spacing_i);
    match     = (diff <= (run_ref_q >> TOL_SHIFT));
    start_new = (run_cnt_q == '0) | ~match;
    nxt_sum   = start_new ? spacing_ext : (run_sum_q + spacing_ext);
    nxt_cnt   = start_new ? RUN_ONE : (run_cnt_q + RUN_ONE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_ref_q <= '0;
      run_sum_q <= '0;
      run_cnt_q <= '0;
      locked_q  <= 1'b0;
      period_q  <= '0;
    end else if (spacing_vld_i && !locked_q) begin
      if (start_new) run_ref_q <= spacing_i;
      run_sum_q <= nxt_sum;
      run_cnt_q <= nxt_cnt;
      if (nxt_cnt == RUN_FULL) begin
        locked_q <= 1'b1;
        period_q <= nxt_sum[SUM_W-1:AVG_LOG2];
      end
    end
  end

  assign locked_o = locked_q;
  assign period_o = period_q;
endmodule

// File: rtl/fpd_parity_judge.sv
`timescale 1ns/1ps
// Classifies the vertical-start phase and updates the field output.
module fpd_parity_judge
  import fpd_pkg::*;
#(
  parameter int CNT_W     = 12,
  parameter int TOL_SHIFT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vstart_i,
  input  logic             accept_i,
  input  logic             ref_valid_i,
  input  logic [CNT_W-1:0] gap_i,
  input  logic             locked_i,
  input  logic [CNT_W-1:0] period_i,
  output verdict_e         verdict_o,
  output logic             field_odd_o
);
  logic [CNT_W-1:0] phase;
  logic [CNT_W-1:0] tol;
  logic [CNT_W-1:0] half;
  logic [CNT_W-1:0] dist_half;
  logic             field_q;

  always_comb begin
    phase     = accept_i ? '0 : gap_i;
    tol       = period_i >> TOL_SHIFT;
    half      = period_i >> 1;
    dist_half = (phase > half) ? (phase - half) : (half - phase);
    if (!locked_i || !(ref_valid_i || accept_i))
      verdict_o = VERD_UNSURE;
    else if (phase <= tol || phase >= (period_i - tol))
      verdict_o = VERD_ODD;
    else if (dist_half <= tol)
      verdict_o = VERD_EVEN;
    else
      verdict_o = VERD_UNSURE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      field_q <= 1'b0;
    end else if (vstart_i) begin
      unique case (verdict_o)
        VERD_ODD:  field_q <= 1'b1;
        VERD_EVEN: field_q <= 1'b0;
        default:   field_q <= ~field_q;
      endcase
    end
  end

  assign field_odd_o = field_q;
endmodule

// File: rtl/field_parity_top.sv
`timescale 1ns/1ps
module field_parity_top #(
  parameter int CNT_W     = 12,
  parameter int AVG_LOG2  = 2,
  parameter int TOL_SHIFT = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic csync_i,
  input  logic vstart_i,
  output logic field_odd_o
);
  import fpd_pkg::*;

  logic             accept;
  logic             ref_valid;
  logic             spacing_vld;
  logic [CNT_W-1:0] gap;
  logic             locked;
  logic [CNT_W-1:0] period;
  verdict_e         verdict;

  fpd_edge_gate #(.CNT_W(CNT_W), .TOL_SHIFT(TOL_SHIFT)) u_edge (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .csync_i      (csync_i),
    .locked_i     (locked),
    .period_i     (period),
    .accept_o     (accept),
    .ref_valid_o  (ref_valid),
    .spacing_vld_o(spacing_vld),
    .gap_o        (gap)
  );

  fpd_period_learn #(.CNT_W(CNT_W), .AVG_LOG2(AVG_LOG2), .TOL_SHIFT(TOL_SHIFT)) u_learn (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .spacing_vld_i(spacing_vld),
    .spacing_i    (gap),
    .locked_o     (locked),
    .period_o     (period)
  );

  fpd_parity_judge #(.CNT_W(CNT_W), .TOL_SHIFT(TOL_SHIFT)) u_judge (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .vstart_i   (vstart_i),
    .accept_i   (accept),
    .ref_valid_i(ref_valid),
    .gap_i      (gap),
    .locked_i   (locked),
    .period_i   (period),
    .verdict_o  (verdict),
    .field_odd_o(field_odd_o)
  );
endmodule

// File: rtl/fpd_checker.sv
`timescale 1ns/1ps
module fpd_checker
  import fpd_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             vstart_i,
  input logic             field_odd_o,
  input logic             accept,
  input logic [CNT_W-1:0] gap,
  input logic             locked,
  input logic [CNT_W-1:0] period,
  input verdict_e         verdict
);
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      assert_reset_clear_R1: assert (!field_odd_o && !locked)
        else $error("reset state not clear");
    end
  end

  assert_hold_between_strobes_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(vstart_i) |-> $stable(field_odd_o));

  assert_lock_sticky_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked |=> locked);

  assert_period_nonzero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked |-> (period != '0));

  assert_unlocked_unsure_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !locked |-> (verdict == VERD_UNSURE));

  assert_ref_restart_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> (gap == CNT_W'(1)));

  assert_odd_sets_high_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vstart_i && verdict == VERD_ODD) |=> field_odd_o);

  assert_even_sets_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vstart_i && verdict == VERD_EVEN) |=> !field_odd_o);

  assert_unsure_toggles_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vstart_i && verdict == VERD_UNSURE) |=> (field_odd_o != $past(field_odd_o)));
endmodule

bind field_parity_top fpd_checker #(.CNT_W(CNT_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .vstart_i   (vstart_i),
  .field_odd_o(field_odd_o),
  .accept     (accept),
  .gap        (gap),
  .locked     (locked),
  .period     (period),
  .verdict    (verdict)
);

// File: tb/field_parity_top_bench.sv
`timescale 1ns/1ps
module field_parity_top_bench;
  localparam int CLK_NS = 4;
  localparam int SYNC_W = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic csync_i = 1'b1;
  logic vstart_i = 1'b0;
  logic field_odd_o;

  int  n_chk = 0;
  int  n_err = 0;
  int  cyc = 0;
  int  lp = 64;
  bit  eq_en = 1'b0;
  int  eq_pos = 32;
  logic exp_f = 1'b0;
  bit  done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  field_parity_top u_field_parity_top (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .csync_i    (csync_i),
    .vstart_i   (vstart_i),
    .field_odd_o(field_odd_o)
  );

  function automatic logic decide(int k, int p, logic prev);
    int tol, half, d;
    tol  = p >> 3;
    half = p >> 1;
    if (k <= tol || k >= p - tol) return 1'b1;
    d = (k > half) ? k - half : half - k;
    if (d <= tol) return 1'b0;
    return ~prev;
  endfunction

  task automatic chk(string req, logic exp);
    n_chk++;
    if (field_odd_o !== exp) begin
      n_err++;
      $display("FAIL %s: field_odd_o=%0b expected %0b (cycle %0d)", req, field_odd_o, exp, cyc);
    end
  endtask

  task automatic tick(logic vs);
    int m;
    @(negedge clk);
    m = cyc % lp;
    csync_i  = !((m < SYNC_W) || (eq_en && m >= eq_pos && m < eq_pos + SYNC_W));
    vstart_i = vs;
    cyc++;
  endtask

  // strobe vertical start at line phase k, then check the updated output
  task automatic pulse_at(int k, string req, bit use_exp, logic forced);
    while ((cyc % lp) != k) tick(1'b0);
    tick(1'b1);
    tick(1'b0);
    exp_f = use_exp ? forced : decide(k, lp, exp_f);
    chk(req, exp_f);
  endtask

  task automatic do_reset(int p);
    @(negedge clk);
    rst_ni = 1'b0; csync_i = 1'b1; vstart_i = 1'b0; eq_en = 1'b0;
    repeat (3) @(negedge clk);
    lp = p; cyc = 0; exp_f = 1'b0;
    chk("R1 reset low", 1'b0);
    rst_ni = 1'b1;
  endtask

  task automatic run_rate(int p, string rate_req);
    do_reset(p);
    // before lock every strobe is undecidable: toggles
    pulse_at(10, "R1 first strobe after reset toggles", 1'b1, 1'b1);
    pulse_at(10, "R3 unlocked strobe toggles", 1'b1, 1'b0);
    while (cyc < 6 * lp) tick(1'b0);
    for (int k = 0; k < lp; k++) begin
      if (k <= (lp >> 3) || k >= lp - (lp >> 3))
        pulse_at(k, {rate_req, " R5 whole-line phase"}, 1'b0, 1'b0);
      else if ((k > (lp >> 1) ? k - (lp >> 1) : (lp >> 1) - k) <= (lp >> 3))
        pulse_at(k, {rate_req, " R6 half-line phase"}, 1'b0, 1'b0);
      else
        pulse_at(k, {rate_req, " R7 undecidable phase"}, 1'b0, 1'b0);
    end
  endtask

  initial begin
    logic held;
    bit   moved;
    // rate 1: P = 64
    run_rate(64, "R3");
    // R8: interlaced alternation then progressive hold
    pulse_at(32, "R8 alternation even", 1'b1, 1'b0);
    pulse_at(0,  "R8 alternation odd",  1'b1, 1'b1);
    pulse_at(32, "R8 alternation even", 1'b1, 1'b0);
    pulse_at(0,  "R8 progressive odd",  1'b1, 1'b1);
    pulse_at(0,  "R8 progressive holds", 1'b1, 1'b1);
    pulse_at(0,  "R8 progressive holds", 1'b1, 1'b1);
    // R4: half-line pulse at 32 must not restart the reference; phase 60 stays odd
    eq_en = 1'b1;
    pulse_at(60, "R4 equalizing pulse ignored", 1'b1, 1'b1);
    eq_en = 1'b0;
    pulse_at(30, "R4 reference kept after equalizing", 1'b1, 1'b0);
    // R2: stable for three lines without a strobe
    held = field_odd_o; moved = 1'b0;
    for (int i = 0; i < 3 * lp; i++) begin
      tick(1'b0);
      if (field_odd_o !== held) moved = 1'b1;
    end
    n_chk++;
    if (moved) begin
      n_err++;
      $display("FAIL R2 output moved without strobe: expected %0b held", held);
    end
    // rate 2: P = 40, relearned after reset
    run_rate(40, "R9");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule